// File: doc/BRIEF.md
# Video Line-Event Interrupt Controller

This block turns three timing events from a video raster generator into one active-high interrupt line for a host processor. The three events are the start of vertical sync, the start of line 21 and the start of line 284. Each arrives as a single-cycle pulse. Each source has an enable bit. When a source is enabled, its pulse sets a sticky pending flag. The interrupt output stays high while any pending flag is set.

Software reaches the block through a small synchronous register port. It has three registers:
- an enable register, which can be written and read back;
- a write-one-to-clear register, which reads as zero;
- a read-only status register, which shows the pending flags.

Only an explicit write of a one removes a pending flag. Dropping a source's enable stops new events from that source but does not cancel a flag that is already set. Because of this, a handler never loses an event that arrived before it reconfigured the sources.

Top module: `lei_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable register reads 0, the status register reads 0 and `irq_o` is low.
- R2: Source bit positions are bit 0 = vertical sync, bit 1 = line 21 and bit 2 = line 284, in every register and on `evt_i`. Register addresses are 0 = enable (read/write), 1 = clear (write-one-to-clear, reads 0) and 2 = status (read-only). Address 3 reads 0. Written data bits above bit 2 are ignored.
- R3: If an event pulse arrives while its enable bit is 1, the pending flag is set at that clock edge. The flag is visible in the status register and on `irq_o` from the next cycle on.
- R4: An event pulse whose enable bit is 0 leaves the status register and `irq_o` unchanged.
- R5: `irq_o` is high exactly while at least one pending flag is set.
- R6: Clearing a source's enable bit does not clear its pending flag and does not drop `irq_o`.
- R7: Writing the clear register clears exactly those pending flags whose data bit is 1. Zero bits, and a write of all zeros, change nothing.
- R8: If an enabled event and a clear of the same bit arrive in the same cycle, the flag stays set.
- R9: A write to the enable register takes effect at its clock edge. An event in that same cycle is judged against the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 3 | Single-cycle event pulses (bit 0 vsync, bit 1 line 21, bit 2 line 284) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq_o | output | 1 | Active-high interrupt |

## Verification
Assertions in each flag slice check the flag's behaviour on every cycle:
- an enabled event always sets the flag;
- the flag never rises without an enabled event;
- the flag falls only under a clear that has no event in the same cycle.

Further assertions at the top and in the register logic check that:
- the interrupt stays high while some flag is pending and no clear is written;
- the enable register changes only when its own address is written.

Only the bench's scenarios can show the following, because they depend on software-visible sequences:
- the register address map and the bit positions;
- that the clear register reads as zero;
- that an enable write races correctly against an event in the same cycle;
- that only the selected bits of a partial clear are removed.

// File: rtl/lei_pkg.sv
// Package: shared constants for the line-event interrupt controller.
// Assumes a two-bit register address space; source bit order is fixed.
package lei_pkg;
    localparam int LEI_ADDR_W = 2;

    localparam logic [LEI_ADDR_W-1:0] ADDR_ENABLE = 2'd0;
    localparam logic [LEI_ADDR_W-1:0] ADDR_CLEAR  = 2'd1;
    localparam logic [LEI_ADDR_W-1:0] ADDR_STATUS = 2'd2;

    localparam int SRC_VSYNC  = 0;
    localparam int SRC_LINE21 = 1;
    localparam int SRC_LINE284 = 2;
endpackage

// File: rtl/lei_src_flag.sv
// Module: one sticky pending flag for a single event source.
// The flag sets on an event pulse while enabled and clears on a clear strobe.
// If set and clear arrive together, set wins.
// Assumes evt_i is a one-cycle pulse synchronous to clk.
module lei_src_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_q;

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (evt_i && en_i)
            pend_q <= 1'b1;
        else if (clr_i)
            pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    // R3 / R8
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && en_i) |=> pend_o);

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !(evt_i && en_i)) |=> !pend_o);

    // R6 / R7
    only_clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && clr_i && !(evt_i && en_i)) |=> !pend_o);
endmodule

// File: rtl/lei_regs.sv
// Module: register file for the line-event interrupt controller.
// It holds the enable register and decodes write-one-to-clear strobes.
// It also provides combinational readback of enable, clear (reads 0) and status.
// Assumes DATA_W >= NUM_SRC.
module lei_regs #(
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [lei_pkg::LEI_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [lei_pkg::LEI_ADDR_W-1:0] rd_addr,
    input  logic [NUM_SRC-1:0]            pend_i,
    output logic [NUM_SRC-1:0]            en_o,
    output logic [NUM_SRC-1:0]            clr_o,
    output logic [DATA_W-1:0]             rd_data
);
    import lei_pkg::*;

    logic [NUM_SRC-1:0] en_q;
    logic               wr_enable;
    logic               wr_clear;

    // Address decode for the two writable registers.
    assign wr_enable = wr_en && (wr_addr == ADDR_ENABLE);
    assign wr_clear  = wr_en && (wr_addr == ADDR_CLEAR);

    // Enable register: loaded from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_enable)
            en_q <= wr_data[NUM_SRC-1:0];
    end

    // Clear strobes: only the bits written as one.
    always_comb begin
        clr_o = '0;
        if (wr_clear)
            clr_o = wr_data[NUM_SRC-1:0];
    end

    // Read mux; the clear register and unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_ENABLE: rd_data[NUM_SRC-1:0] = en_q;
            ADDR_STATUS: rd_data[NUM_SRC-1:0] = pend_i;
            default:     rd_data = '0;
        endcase
    end

    assign en_o = en_q;

    // R2 / R9
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_ENABLE) |=> $stable(en_o));
endmodule

// File: rtl/lei_irq_ctrl.sv
// Module: top of the line-event interrupt controller.
// Three event sources feed sticky flags; their OR drives an active-high interrupt.
// Assumes event pulses and register accesses are synchronous to clk.
module lei_irq_ctrl #(
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            evt_i,
    input  logic                          wr_en,
    input  logic [lei_pkg::LEI_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [lei_pkg::LEI_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          irq_o
);
    import lei_pkg::*;

    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend;

    lei_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .pend_i (pend),
        .en_o   (en),
        .clr_o  (clr),
        .rd_data(rd_data)
    );

    // One sticky flag per source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        lei_src_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_i[s]),
            .en_i  (en[s]),
            .clr_i (clr[s]),
            .pend_o(pend[s])
        );
    end

    // Interrupt is the OR of all pending flags.
    assign irq_o = |pend;

    // R5 / R6
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_en && wr_addr == ADDR_CLEAR)) |=> irq_o);

    // R4 / R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && ((evt_i & en) == '0)) |=> !irq_o);
endmodule

// File: tb/test_lei_irq_ctrl.sv
module test_lei_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] evt_i = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lei_irq_ctrl i_lei_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Read at mid-cycle (after a negedge), combinational port.
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // One cycle with optional write and events; returns at the next negedge.
    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d, input logic [2:0] e);
        wr_en = w; wr_addr = a; wr_data = d; evt_i = e;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; evt_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        rd(0, d); check("R1 enable", d, 0);
        rd(2, d); check("R1 status", d, 0);
        check("R1 irq", irq_o, 0);
    endtask

    task automatic t_map();
        logic [7:0] d;
        do_reset();
        cyc(1, 0, 8'hFD, 0);
        rd(0, d); check("R2 enable readback upper bits ignored", d, 8'h05);
        rd(1, d); check("R2 clear reads zero", d, 0);
        rd(3, d); check("R2 unmapped reads zero", d, 0);
    endtask

    task automatic t_set_each();
        logic [7:0] d;
        for (int s = 0; s < 3; s++) begin
            do_reset();
            cyc(1, 0, 8'h07, 0);
            cyc(0, 0, 0, 3'(1 << s));
            rd(2, d); check("R3 status bit set", d, 1 << s);
            check("R3 irq high", irq_o, 1);
        end
    endtask

    task automatic t_masked();
        logic [7:0] d;
        do_reset();
        cyc(1, 0, 8'h02, 0);
        cyc(0, 0, 0, 3'b101);
        rd(2, d); check("R4 masked events ignored", d, 0);
        check("R4 irq low", irq_o, 0);
    endtask

    task automatic t_or_and_clear();
        logic [7:0] d;
        do_reset();
        cyc(1, 0, 8'h07, 0);
        cyc(0, 0, 0, 3'b011);
        cyc(1, 1, 8'h00, 0);
        rd(2, d); check("R7 zero write no effect", d, 8'h03);
        cyc(1, 1, 8'h01, 0);
        rd(2, d); check("R7 selective clear", d, 8'h02);
        check("R5 irq high with one left", irq_o, 1);
        cyc(1, 1, 8'h02, 0);
        check("R5 irq low when none pending", irq_o, 0);
    endtask

    task automatic t_disable_keeps();
        logic [7:0] d;
        do_reset();
        cyc(1, 0, 8'h04, 0);
        cyc(0, 0, 0, 3'b100);
        cyc(1, 0, 8'h00, 0);
        rd(2, d); check("R6 flag kept after disable", d, 8'h04);
        check("R6 irq kept after disable", irq_o, 1);
        cyc(1, 1, 8'h04, 0);
        check("R6 explicit clear drops irq", irq_o, 0);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        do_reset();
        cyc(1, 0, 8'h01, 0);
        cyc(0, 0, 0, 3'b001);
        cyc(1, 1, 8'h01, 3'b001);
        rd(2, d); check("R8 set wins over clear", d, 8'h01);
    endtask

    task automatic t_enable_race();
        logic [7:0] d;
        do_reset();
        cyc(1, 0, 8'h02, 3'b010);
        rd(2, d); check("R9 old enable used", d, 0);
        cyc(0, 0, 0, 3'b010);
        rd(2, d); check("R9 new enable active", d, 8'h02);
        cyc(1, 0, 8'h00, 3'b001);
        rd(2, d); check("R9 event during disable write", d, 8'h02);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_map();
        t_set_each();
        t_masked();
        t_or_and_clear();
        t_disable_keeps();
        t_collision();
        t_enable_race();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule